// File: doc/BRIEF.md
# Byte-Wide SPI Port with Write-Collision Flag

This block is a register-mapped serial peripheral interface that moves one byte per transfer. It acts as the clock-driving master or as a slave clocked from outside. A host reaches it through a small register interface with a control register, a status register and a data register. Its serial side has an SCK output and input, a data output and input, and an active-low chip select in each direction. In master mode a write to the data register starts the transfer at once. In slave mode the written byte waits in the shift register until an outside master supplies clock edges.

The block latches a received byte into the readable data register only after all bits have arrived. It then raises a sticky transfer-done flag, which is also the interrupt output. The data register cannot be written while a transfer is running: such a write is dropped and a sticky collision flag is raised. Three build-time parameters control the rest. One chooses which SCK edge samples data. One can remove the collision flag. One can remove the effect of the chip-select control bit.

Register map by `reg_addr`: 0 = control, 1 = status, 2 = data.

Control layout: bit 0 = enable, bits 2:1 = mode, bit 3 = LSB-first, bit 4 = chip-select enable, bits 6:5 = divider.

Status layout: bit 0 = done, bit 1 = collision, bit 2 = busy.

Top module: `spi_byte_port`

## Requirements
- R1: After reset, the control, status and data registers read 0. `irq` is 0, `ss_n_o` is 1, and `sck_o` sits at its idle level.
- R2: A read with `reg_rd` high returns the addressed register on `reg_rdata` one clock later. Control reads back exactly as written, using the layout control[0]=enable, [2:1]=mode, [3]=LSB-first, [4]=chip-select enable, [6:5]=divider.
- R3: With enable set and mode not 00, a write to the data register starts a master transfer. The transfer has 8 SCK cycles, each lasting 2^(divider+1) system clocks. `ss_n_o` is low during the transfer when chip select is active, and returns high afterwards.
- R4: With LSB-first clear, bit 7 is shifted out and received first. With it set, bit 0 goes first.
- R5: The readable data register keeps its previous value during a transfer. It takes the received byte only when the last bit has been sampled.
- R6: At the end of each byte, status bit 0 sets and `irq` goes high. Both stay high until the host writes status with bit 0 set (write-one-to-clear).
- R7: A data-register write while busy is discarded, and the byte in flight is unchanged. With COLL_EN=1 it sets status bit 1.
- R8: The collision flag stays set until the host writes status with bit 1 set.
- R9: With COLL_EN=0 the collision flag never sets, and in-flight writes are still discarded.
- R10: Mode 00 is slave mode. In this mode the divider field is ignored, `sck_o` stays idle, and the loaded byte waits until edges arrive on `sck_i`.
- R11: In slave mode with chip-select enable set, `sck_i` edges are ignored while `ss_n_i` is high. With chip-select enable clear, the slave responds whatever the level of `ss_n_i`.
- R12: With CS_EN=0 the chip-select enable bit has no effect: `ss_n_o` stays high and the slave ignores `ss_n_i`.
- R13: With SCK_RISE=1, SCK idles low and data is sampled on rising edges. With SCK_RISE=0, SCK idles high and data is sampled on falling edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Transfer-done interrupt, level |
| sck_o | output | 1 | Master serial clock |
| sck_i | input | 1 | Serial clock from an outside master |
| ss_n_o | output | 1 | Chip select driven as master, active low |
| ss_n_i | input | 1 | Chip select received as slave, active low |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The checker watches a fixed set of properties on every clock:
- the stickiness of the done and collision flags;
- a collision write always raising the flag;
- `irq` following each completed byte;
- SCK resting at its idle level whenever the master is idle;
- chip select staying high when the feature is built out.

Several behaviours can only be shown by the bench's scenarios, because they depend on values over a whole transfer:
- the bit order and the SCK period at each divider setting;
- loopback of the received byte;
- the data register holding its old value partway through a transfer;
- the discarded write leaving the byte in flight intact;
- the slave ignoring edges while deselected.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd2;

  localparam int ST_DONE = 0;
  localparam int ST_COLL = 1;
  localparam int ST_BUSY = 2;

  // Field order fixes the bit layout: div[6:5] cs[4] lsb[3] mode[2:1] en[0]
  typedef struct packed {
    logic [1:0] div;
    logic       cs;
    logic       lsb;
    logic [1:0] mode;
    logic       en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/spi_clkgen.sv
module spi_clkgen #(
  parameter int  DATA_W   = 8,
  parameter int  DIV_W    = 2,
  parameter bit  SCK_RISE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DIV_W-1:0] div,
  output logic             sck,
  output logic             active,
  output logic             sample_stb,
  output logic             shift_stb
);

  localparam int   HC_W = (1 << DIV_W) - 1;
  localparam int   TG_W = $clog2(2 * DATA_W);
  localparam logic IDLE = SCK_RISE ? 1'b0 : 1'b1;

  logic [HC_W-1:0] half_cnt;
  logic [HC_W-1:0] half_m1;
  logic [TG_W-1:0] tog_cnt;
  logic            tick;

  always_comb begin
    half_m1    = HC_W'((1 << div) - 1);
    tick       = active && (half_cnt == half_m1);
    sample_stb = tick && !tog_cnt[0];
    shift_stb  = tick && tog_cnt[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      sck      <= IDLE;
      half_cnt <= '0;
      tog_cnt  <= '0;
    end else if (start && !active) begin
      active   <= 1'b1;
      half_cnt <= '0;
      tog_cnt  <= '0;
    end else if (active) begin
      if (tick) begin
        half_cnt <= '0;
        sck      <= ~sck;
        tog_cnt  <= tog_cnt + 1'b1;
        if (tog_cnt == TG_W'(2 * DATA_W - 1)) begin
          active <= 1'b0;
        end
      end else begin
        half_cnt <= half_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/spi_slave_front.sv
module spi_slave_front #(
  parameter bit SCK_RISE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_i,
  input  logic ss_n_i,
  output logic samp_edge,
  output logic shift_edge,
  output logic ss_high
);

  localparam logic IDLE = SCK_RISE ? 1'b0 : 1'b1;

  logic [1:0] sck_s;
  logic [1:0] ss_s;
  logic       sck_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_s    <= {2{IDLE}};
      ss_s     <= 2'b11;
      sck_prev <= IDLE;
    end else begin
      sck_s    <= {sck_s[0], sck_i};
      ss_s     <= {ss_s[0], ss_n_i};
      sck_prev <= sck_s[1];
    end
  end

  always_comb begin
    samp_edge  = (sck_s[1] != sck_prev) && (sck_s[1] != IDLE);
    shift_edge = (sck_s[1] != sck_prev) && (sck_s[1] == IDLE);
    ss_high    = ss_s[1];
  end

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              lsb_first,
  input  logic              clr,
  input  logic              sample,
  input  logic              shift,
  input  logic              sdi,
  output logic              sdo,
  output logic              busy,
  output logic              byte_done,
  output logic [DATA_W-1:0] rx_byte
);

  localparam int CNT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] sh;
  logic [DATA_W-1:0] nxt;
  logic [CNT_W-1:0]  cnt;

  always_comb begin
    nxt       = lsb_first ? {sdi, sh[DATA_W-1:1]} : {sh[DATA_W-2:0], sdi};
    rx_byte   = nxt;
    busy      = (cnt != '0);
    byte_done = sample && !load && !clr && (cnt == CNT_W'(DATA_W - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh  <= '0;
      cnt <= '0;
      sdo <= 1'b0;
    end else if (load) begin
      sh  <= load_data;
      cnt <= '0;
      sdo <= lsb_first ? load_data[0] : load_data[DATA_W-1];
    end else if (clr) begin
      cnt <= '0;
    end else if (sample) begin
      sh  <= nxt;
      cnt <= (cnt == CNT_W'(DATA_W - 1)) ? '0 : cnt + 1'b1;
    end else if (shift && busy) begin
      sdo <= lsb_first ? sh[0] : sh[DATA_W-1];
    end
  end

endmodule

// File: rtl/spi_byte_port.sv
module spi_byte_port
  import spi_port_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DIV_W    = 2,
  parameter bit COLL_EN  = 1'b1,
  parameter bit CS_EN    = 1'b1,
  parameter bit SCK_RISE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              sck_o,
  input  logic              sck_i,
  output logic              ss_n_o,
  input  logic              ss_n_i,
  output logic              sdo,
  input  logic              sdi
);

  ctrl_t             ctrl_q;
  logic              done_q;
  logic              coll_q;
  logic [DATA_W-1:0] rx_q;
  logic [DATA_W-1:0] rdata_q;
  logic              ss_q;

  logic              master, cs_on;
  logic              data_wr, stat_wr, ctrl_wr;
  logic              busy, accept, m_start;
  logic              clr_done, clr_coll;
  logic              m_active, m_sample, m_shift;
  logic              s_samp, s_shift, ss_high, s_on;
  logic              sample, shift, sh_clr, s_busy;
  logic              byte_done;
  logic [DATA_W-1:0] rx_byte;

  always_comb begin
    master   = (ctrl_q.mode != 2'b00);
    cs_on    = CS_EN && ctrl_q.cs;
    ctrl_wr  = reg_wr && (reg_addr == ADDR_CTRL);
    stat_wr  = reg_wr && (reg_addr == ADDR_STAT);
    data_wr  = reg_wr && (reg_addr == ADDR_DATA);
    busy     = m_active || s_busy;
    accept   = data_wr && !busy;
    m_start  = accept && ctrl_q.en && master;
    clr_done = stat_wr && reg_wdata[ST_DONE];
    clr_coll = stat_wr && reg_wdata[ST_COLL];
    s_on     = ctrl_q.en && !master && !(cs_on && ss_high);
    sh_clr   = !master && cs_on && ss_high;
    sample   = m_active ? m_sample : (s_on && s_samp);
    shift    = m_active ? m_shift  : (s_on && s_shift);
  end

  spi_clkgen #(
    .DATA_W  (DATA_W),
    .DIV_W   (DIV_W),
    .SCK_RISE(SCK_RISE)
  ) u_clkgen (
    .clk       (clk),
    .rst       (rst),
    .start     (m_start),
    .div       (ctrl_q.div),
    .sck       (sck_o),
    .active    (m_active),
    .sample_stb(m_sample),
    .shift_stb (m_shift)
  );

  spi_slave_front #(
    .SCK_RISE(SCK_RISE)
  ) u_front (
    .clk       (clk),
    .rst       (rst),
    .sck_i     (sck_i),
    .ss_n_i    (ss_n_i),
    .samp_edge (s_samp),
    .shift_edge(s_shift),
    .ss_high   (ss_high)
  );

  spi_shifter #(
    .DATA_W(DATA_W)
  ) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_data(reg_wdata),
    .lsb_first(ctrl_q.lsb),
    .clr      (sh_clr),
    .sample   (sample),
    .shift    (shift),
    .sdi      (sdi),
    .sdo      (sdo),
    .busy     (s_busy),
    .byte_done(byte_done),
    .rx_byte  (rx_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      done_q  <= 1'b0;
      coll_q  <= 1'b0;
      rx_q    <= '0;
      rdata_q <= '0;
      ss_q    <= 1'b1;
    end else begin
      if (ctrl_wr) begin
        ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
      end

      if (byte_done) begin
        done_q <= 1'b1;
        rx_q   <= rx_byte;
      end else if (clr_done) begin
        done_q <= 1'b0;
      end

      if (COLL_EN && data_wr && busy) begin
        coll_q <= 1'b1;
      end else if (clr_coll) begin
        coll_q <= 1'b0;
      end

      if (m_start && cs_on) begin
        ss_q <= 1'b0;
      end else if (!m_active) begin
        ss_q <= 1'b1;
      end

      if (reg_rd) begin
        case (reg_addr)
          ADDR_CTRL: rdata_q <= DATA_W'(ctrl_q);
          ADDR_STAT: rdata_q <= DATA_W'({busy, coll_q, done_q});
          ADDR_DATA: rdata_q <= rx_q;
          default:   rdata_q <= '0;
        endcase
      end
    end
  end

  assign reg_rdata = rdata_q;
  assign irq       = done_q;
  assign ss_n_o    = ss_q;

endmodule

// File: rtl/spi_byte_port_chk.sv
module spi_byte_port_chk #(
  parameter bit COLL_EN  = 1'b1,
  parameter bit CS_EN    = 1'b1,
  parameter bit SCK_RISE = 1'b1
) (
  input logic clk,
  input logic rst,
  input logic data_wr,
  input logic busy,
  input logic coll_q,
  input logic clr_coll,
  input logic clr_done,
  input logic byte_done,
  input logic irq,
  input logic sck_o,
  input logic m_active,
  input logic ss_n_o
);

  localparam logic IDLE = SCK_RISE ? 1'b0 : 1'b1;

  assert_coll_set_R7: assert property (@(posedge clk) disable iff (rst)
    (COLL_EN && data_wr && busy) |=> coll_q);

  assert_coll_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (coll_q && !clr_coll) |=> coll_q);

  assert_done_irq_R6: assert property (@(posedge clk) disable iff (rst)
    byte_done |=> irq);

  assert_done_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr_done) |=> irq);

  assert_sck_idle_R13: assert property (@(posedge clk) disable iff (rst)
    !m_active |-> (sck_o == IDLE));

  assert_ss_release_R3: assert property (@(posedge clk) disable iff (rst)
    (!m_active && !$past(m_active)) |-> ss_n_o);

  if (!COLL_EN) begin : g_no_coll
    assert_coll_off_R9: assert property (@(posedge clk) disable iff (rst)
      !coll_q);
  end

  if (!CS_EN) begin : g_no_cs
    assert_ss_off_R12: assert property (@(posedge clk) disable iff (rst)
      ss_n_o);
  end

endmodule

bind spi_byte_port spi_byte_port_chk #(
  .COLL_EN (COLL_EN),
  .CS_EN   (CS_EN),
  .SCK_RISE(SCK_RISE)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .data_wr  (data_wr),
  .busy     (busy),
  .coll_q   (coll_q),
  .clr_coll (clr_coll),
  .clr_done (clr_done),
  .byte_done(byte_done),
  .irq      (irq),
  .sck_o    (sck_o),
  .m_active (m_active),
  .ss_n_o   (ss_n_o)
);

// File: tb/spi_byte_port_tb.sv
module spi_byte_port_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [1:0]      reg_wr, reg_rd;
  logic [1:0][1:0] reg_addr;
  logic [1:0][7:0] reg_wdata, reg_rdata;
  logic [1:0]      irq, sck_o, ss_n_o, sdo;
  logic [1:0]      sck_drv, ss_drv, sdi_drv, loop_en, sdi;

  int checks = 0;
  int errors = 0;

  assign sdi[0] = loop_en[0] ? sdo[0] : sdi_drv[0];
  assign sdi[1] = loop_en[1] ? sdo[1] : sdi_drv[1];

  // Instance A: collision and chip select present, rising-edge sampling
  spi_byte_port u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr[0]), .reg_rd(reg_rd[0]),
    .reg_addr(reg_addr[0]), .reg_wdata(reg_wdata[0]), .reg_rdata(reg_rdata[0]),
    .irq(irq[0]), .sck_o(sck_o[0]), .sck_i(sck_drv[0]), .ss_n_o(ss_n_o[0]),
    .ss_n_i(ss_drv[0]), .sdo(sdo[0]), .sdi(sdi[0])
  );

  // Instance B: both features built out, falling-edge sampling
  spi_byte_port #(.COLL_EN(1'b0), .CS_EN(1'b0), .SCK_RISE(1'b0)) u_dut_b (
    .clk(clk), .rst(rst), .reg_wr(reg_wr[1]), .reg_rd(reg_rd[1]),
    .reg_addr(reg_addr[1]), .reg_wdata(reg_wdata[1]), .reg_rdata(reg_rdata[1]),
    .irq(irq[1]), .sck_o(sck_o[1]), .sck_i(sck_drv[1]), .ss_n_o(ss_n_o[1]),
    .ss_n_i(ss_drv[1]), .sdo(sdo[1]), .sdi(sdi[1])
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mk_ctrl(input bit en, input logic [1:0] mode,
                                         input bit lsb, input bit cs,
                                         input logic [1:0] div);
    return {1'b0, div, cs, lsb, mode, en};
  endfunction

  task automatic host_write(input int w, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr[w] = 1'b1; reg_addr[w] = a; reg_wdata[w] = d;
    @(negedge clk);
    reg_wr[w] = 1'b0;
  endtask

  task automatic host_read(input int w, input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd[w] = 1'b1; reg_addr[w] = a;
    @(negedge clk);
    reg_rd[w] = 1'b0;
    d = reg_rdata[w];
  endtask

  // act: 0 none, 1 read data register at the 4th sample edge, 2 write data there
  task automatic xfer_master(input int w, input logic [7:0] tx, input bit lsb,
                             input int act, output logic [7:0] sent,
                             output int period, output bit ss_all_low,
                             output bit ss_all_high, output logic [7:0] mid_rd);
    logic idle = (w == 0) ? 1'b0 : 1'b1;
    logic prev = idle;
    int edges = 0;
    int first = 0;
    bit rd_pend = 0;
    sent = '0; period = 0; ss_all_low = 1; ss_all_high = 1; mid_rd = '0;
    host_write(w, 2'd2, tx);
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      reg_wr[w] = 1'b0;
      reg_rd[w] = 1'b0;
      if (rd_pend) begin
        mid_rd = reg_rdata[w];
        rd_pend = 0;
      end
      if (sck_o[w] != prev && sck_o[w] != idle) begin
        edges++;
        if (edges == 1) first = c;
        if (edges == 2) period = c - first;
        sent = lsb ? {sdo[w], sent[7:1]} : {sent[6:0], sdo[w]};
        if (ss_n_o[w]) ss_all_low = 0;
        else ss_all_high = 0;
        if (edges == 4 && act == 1) begin
          reg_rd[w] = 1'b1; reg_addr[w] = 2'd2; rd_pend = 1;
        end
        if (edges == 4 && act == 2) begin
          reg_wr[w] = 1'b1; reg_addr[w] = 2'd2; reg_wdata[w] = 8'hFF;
        end
      end
      prev = sck_o[w];
      if (irq[w] && edges == 8) break;
    end
    repeat (40) @(negedge clk);
  endtask

  task automatic xfer_slave(input int w, input logic [7:0] mosi, input bit lsb,
                            output logic [7:0] miso);
    logic idle = (w == 0) ? 1'b0 : 1'b1;
    miso = '0;
    for (int b = 0; b < 8; b++) begin
      sdi_drv[w] = lsb ? mosi[b] : mosi[7-b];
      repeat (8) @(negedge clk);
      miso = lsb ? {sdo[w], miso[7:1]} : {miso[6:0], sdo[w]};
      sck_drv[w] = ~idle;
      repeat (8) @(negedge clk);
      sck_drv[w] = idle;
    end
    repeat (12) @(negedge clk);
  endtask

  task automatic test_reset();
    logic [7:0] d;
    check(irq === 2'b00, "R1 irq after reset", irq, 0);
    check(ss_n_o === 2'b11, "R1 ss_n_o after reset", ss_n_o, 3);
    check(sck_o === 2'b10, "R1 sck idle levels", sck_o, 2);
    host_read(0, 2'd0, d); check(d == 8'h00, "R1 ctrl reset", d, 0);
    host_read(0, 2'd1, d); check(d == 8'h00, "R1 status reset", d, 0);
    host_read(0, 2'd2, d); check(d == 8'h00, "R1 data reset", d, 0);
  endtask

  task automatic test_regs();
    logic [7:0] d;
    host_write(0, 2'd0, 8'h35);
    host_read(0, 2'd0, d); check(d == 8'h35, "R2 ctrl readback", d, 8'h35);
    host_read(0, 2'd1, d); check(d == 8'h00, "R2 ctrl write does not start", d, 0);
  endtask

  task automatic test_master_rates();
    logic [7:0] s, m, d;
    int p;
    bit lo, hi;
    loop_en[0] = 1'b1;
    for (int dv = 0; dv < 4; dv++) begin
      host_write(0, 2'd0, mk_ctrl(1, 2'b01, 0, 1, 2'(dv)));
      xfer_master(0, 8'hA5 ^ 8'(dv), 0, 0, s, p, lo, hi, m);
      check(p == (2 << dv), "R3 sck period", p, 2 << dv);
      check(s == (8'hA5 ^ 8'(dv)), "R4 msb-first bits on sdo", s, 8'hA5 ^ 8'(dv));
      check(lo, "R3 ss_n_o low during transfer", lo, 1);
      check(ss_n_o[0] === 1'b1, "R3 ss_n_o released", ss_n_o[0], 1);
      check(sck_o[0] === 1'b0, "R13 sck idle low after transfer", sck_o[0], 0);
      host_read(0, 2'd2, d);
      check(d == (8'hA5 ^ 8'(dv)), "R5 loopback byte", d, 8'hA5 ^ 8'(dv));
      host_read(0, 2'd1, d); check(d == 8'h01, "R6 done set busy clear", d, 1);
      check(irq[0] === 1'b1, "R6 irq high", irq[0], 1);
      repeat (5) @(negedge clk);
      check(irq[0] === 1'b1, "R6 irq sticky", irq[0], 1);
      host_write(0, 2'd1, 8'h01);
      check(irq[0] === 1'b0, "R6 irq cleared by W1C", irq[0], 0);
    end
  endtask

  task automatic test_lsb_first();
    logic [7:0] s, m, d;
    int p;
    bit lo, hi;
    host_write(0, 2'd0, mk_ctrl(1, 2'b10, 1, 1, 2'd1));
    xfer_master(0, 8'h01, 1, 0, s, p, lo, hi, m);
    check(s == 8'h01, "R4 lsb-first bits on sdo", s, 8'h01);
    host_read(0, 2'd2, d); check(d == 8'h01, "R4 lsb-first loopback", d, 8'h01);
    host_write(0, 2'd1, 8'h03);
  endtask

  task automatic test_collision();
    logic [7:0] s, m, d;
    int p;
    bit lo, hi;
    host_write(0, 2'd0, mk_ctrl(1, 2'b11, 0, 1, 2'd2));
    xfer_master(0, 8'h3C, 0, 1, s, p, lo, hi, m);
    check(m == 8'h01, "R5 data holds old value mid-transfer", m, 8'h01);
    host_read(0, 2'd2, d); check(d == 8'h3C, "R5 data updated at byte end", d, 8'h3C);
    host_write(0, 2'd1, 8'h01);
    xfer_master(0, 8'hC3, 0, 2, s, p, lo, hi, m);
    check(s == 8'hC3, "R7 in-flight byte unchanged", s, 8'hC3);
    host_read(0, 2'd2, d); check(d == 8'hC3, "R7 collision write discarded", d, 8'hC3);
    host_read(0, 2'd1, d); check(d == 8'h03, "R7 collision flag set", d, 8'h03);
    host_write(0, 2'd1, 8'h01);
    repeat (10) @(negedge clk);
    host_read(0, 2'd1, d); check(d == 8'h02, "R8 collision flag sticky", d, 8'h02);
    host_write(0, 2'd1, 8'h02);
    host_read(0, 2'd1, d); check(d == 8'h00, "R8 collision flag cleared", d, 0);
  endtask

  task automatic test_slave();
    logic [7:0] mi, d;
    loop_en[0] = 1'b0;
    host_write(0, 2'd0, mk_ctrl(1, 2'b00, 0, 1, 2'd3));
    host_write(0, 2'd2, 8'h96);
    repeat (50) @(negedge clk);
    host_read(0, 2'd1, d); check(d == 8'h00, "R10 slave does not self-start", d, 0);
    check(sck_o[0] === 1'b0, "R10 sck_o idle in slave mode", sck_o[0], 0);
    ss_drv[0] = 1'b1;
    xfer_slave(0, 8'h11, 0, mi);
    host_read(0, 2'd1, d); check(d == 8'h00, "R11 edges ignored while deselected", d, 0);
    host_read(0, 2'd2, d); check(d == 8'hC3, "R11 data unchanged while deselected", d, 8'hC3);
    ss_drv[0] = 1'b0;
    repeat (4) @(negedge clk);
    xfer_slave(0, 8'h5A, 0, mi);
    ss_drv[0] = 1'b1;
    check(mi == 8'h96, "R10 slave shifts out loaded byte", mi, 8'h96);
    host_read(0, 2'd2, d); check(d == 8'h5A, "R10 slave received byte", d, 8'h5A);
    check(irq[0] === 1'b1, "R6 slave irq", irq[0], 1);
    host_write(0, 2'd1, 8'h01);
    host_write(0, 2'd0, mk_ctrl(1, 2'b00, 1, 0, 2'd0));
    host_write(0, 2'd2, 8'h0F);
    xfer_slave(0, 8'h81, 1, mi);
    check(mi == 8'h0F, "R11 no-cs slave lsb-first out", mi, 8'h0F);
    host_read(0, 2'd2, d); check(d == 8'h81, "R11 slave ignores ss when cs bit clear", d, 8'h81);
    host_write(0, 2'd1, 8'h01);
  endtask

  task automatic test_inst_b();
    logic [7:0] s, m, d, mi;
    int p;
    bit lo, hi;
    loop_en[1] = 1'b1;
    host_write(1, 2'd0, mk_ctrl(1, 2'b01, 0, 1, 2'd1));
    xfer_master(1, 8'h6B, 0, 2, s, p, lo, hi, m);
    check(s == 8'h6B, "R13 falling-edge sampled bits", s, 8'h6B);
    check(p == 4, "R13 sck period with falling sampling", p, 4);
    check(hi, "R12 ss_n_o stays high without cs feature", hi, 1);
    check(sck_o[1] === 1'b1, "R13 sck idle high", sck_o[1], 1);
    host_read(1, 2'd2, d); check(d == 8'h6B, "R9 in-flight write discarded", d, 8'h6B);
    host_read(1, 2'd1, d); check(d == 8'h01, "R9 collision flag stays clear", d, 8'h01);
    host_write(1, 2'd1, 8'h01);
    loop_en[1] = 1'b0;
    ss_drv[1] = 1'b1;
    host_write(1, 2'd0, mk_ctrl(1, 2'b00, 0, 1, 2'd0));
    host_write(1, 2'd2, 8'hE7);
    xfer_slave(1, 8'h24, 0, mi);
    check(mi == 8'hE7, "R12 slave sends despite ss high", mi, 8'hE7);
    host_read(1, 2'd2, d); check(d == 8'h24, "R12 cs bit has no effect", d, 8'h24);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    reg_wr = '0; reg_rd = '0; reg_addr = '0; reg_wdata = '0;
    sck_drv = 2'b10; ss_drv = 2'b11; sdi_drv = '0; loop_en = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_regs();
    test_master_rates();
    test_lsb_first();
    test_collision();
    test_slave();
    test_inst_b();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule